// File: doc/BRIEF.md
# Phase Lock Timeout Alarm

This block watches the main clock recovery loop while it tries to reach phase lock on the input that is currently selected. There are fourteen candidate inputs, numbered 1 to 14. Time is counted in whole seconds from a single-cycle tick strobe. If the loop stays unlocked on one input for a programmed number of seconds, the block sets a sticky alarm bit for that input. While the alarm bit is set, the input is also taken out of the eligibility mask that the input selector reads. The time limit is a 6-bit count multiplied by a power-of-two factor.

A mode bit chooses how alarms are cleared. In software mode, an alarm stays set until a write-one-to-clear strobe hits that input's bit. In automatic mode, each alarm runs its own countdown, loaded with the time limit when the alarm is raised. The alarm drops by itself when that countdown runs out, and the clear strobes have no effect. A flag tells the block whether the lock and index inputs belong to the main loop or to the auxiliary loop. Lock failures on the auxiliary loop never raise an alarm.

Top module: `lockTimeoutAlarm`

## Requirements
- R1: The time limit is timeoutVal × factor, where multCode 00→1, 01→2, 10→4 and 11→8. The alarm is raised on the limit-th second tick counted while pathIsPrimary=1, primaryLocked=0 and selIndex is valid and unchanged. The alarm is visible in the cycle after that tick.
- R2: Only alarm bit selIndex−1 is set (bit 0 is input 1, bit 13 is input 14). A selIndex of 0 or above 14 never starts the timer.
- R3: The lock timer returns to zero whenever selIndex changes, and it is held at zero while primaryLocked=1.
- R4: A timeoutVal of 0 never raises an alarm.
- R5: While pathIsPrimary=0, the lock failure belongs to the auxiliary loop and no alarm is raised.
- R6: With autoClear=0, clearStrobe bit i clears alarm bit i. An alarm bit does not clear in any other way.
- R7: With autoClear=1, an alarm clears on the limit-th second tick after the tick that raised it, and clearStrobe has no effect.
- R8: In automatic mode each input runs its own countdown, so alarms on different inputs expire independently.
- R9: When a raise and a software clear hit the same bit in one cycle, the bit ends up set.
- R10: qualMask bit i is 0 exactly when alarm bit i is 1.
- R11: While rstN=0, every alarm, countdown and timer is cleared, so alarm=0 and qualMask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe, once per second |
| pathIsPrimary | input | 1 | 1: lock and index inputs belong to the main loop |
| primaryLocked | input | 1 | Loop reports phase lock |
| selIndex | input | 4 | Selected input number, 1 to 14 |
| timeoutVal | input | 6 | Base timeout count in seconds |
| multCode | input | 2 | Timeout multiplier code |
| autoClear | input | 1 | 1: alarms expire by themselves; 0: software clear |
| clearStrobe | input | 14 | Write-one-to-clear, bit i for input i+1 |
| alarm | output | 14 | Sticky phase lock alarms |
| qualMask | output | 14 | 1 = input eligible for locking |

## Verification
The bench counts ticks one at a time around each limit. A timer that is off by one therefore raises the alarm one tick early or late. The tests change the selected input partway through a run and also assert lock briefly. A design that did not restart its timer on either event would raise an alarm after too few further ticks. In automatic mode, one alarm is raised while another is already counting down. This catches a design that uses one shared countdown: it would either clear both alarms together or reload the older alarm. The tests also drive a clear strobe in the same cycle as a raise, and drive clear strobes in automatic mode. A design with the wrong priority, or with no mode gating on the strobe, would drop the alarm.

// File: rtl/lockTimeoutPkg.sv
package lockTimeoutPkg;
  localparam int unsigned TOV_W  = 6;
  localparam int unsigned MULT_W = 2;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned LIM_W  = TOV_W + (1 << MULT_W) - 1;

  typedef struct packed {
    logic             tick;
    logic             raise;
    logic [IDX_W-1:0] raiseIdx;
    logic [LIM_W-1:0] limit;
  } ctrlStrobes_t;

  function automatic logic [LIM_W-1:0] alarmLimit(input logic [TOV_W-1:0] tov,
                                                   input logic [MULT_W-1:0] code);
    return LIM_W'(tov) << code;
  endfunction
endpackage

// File: rtl/lockTimeoutCtrl.sv
module lockTimeoutCtrl
  import lockTimeoutPkg::*;
#(
  parameter int unsigned NUM_INPUTS = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              pathIsPrimary,
  input  logic              primaryLocked,
  input  logic [IDX_W-1:0]  selIndex,
  input  logic [TOV_W-1:0]  timeoutVal,
  input  logic [MULT_W-1:0] multCode,
  output ctrlStrobes_t      strobes
);
  logic [IDX_W-1:0] prevIndex;
  logic [LIM_W-1:0] lockTimer;
  logic [LIM_W-1:0] limit;
  logic             indexValid;
  logic             armed;
  logic             expire;

  assign limit      = alarmLimit(timeoutVal, multCode);
  assign indexValid = (selIndex != '0) && (selIndex <= IDX_W'(NUM_INPUTS));
  // The timer runs only on the main path, while unlocked, on a stable valid index.
  assign armed      = pathIsPrimary && !primaryLocked && indexValid &&
                      (limit != '0) && (selIndex == prevIndex);
  assign expire     = armed && secTick && (lockTimer >= limit - LIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIndex <= '0;
      lockTimer <= '0;
    end else begin
      prevIndex <= selIndex;
      if (!armed) begin
        lockTimer <= '0;
      end else if (secTick) begin
        lockTimer <= expire ? '0 : lockTimer + LIM_W'(1);
      end
    end
  end

  always_comb begin
    strobes.tick     = secTick;
    strobes.raise    = expire;
    strobes.raiseIdx = selIndex;
    strobes.limit    = limit;
  end
endmodule

// File: rtl/lockTimeoutDatapath.sv
module lockTimeoutDatapath
  import lockTimeoutPkg::*;
#(
  parameter int unsigned NUM_INPUTS = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic                  autoClear,
  input  logic [NUM_INPUTS-1:0] clearStrobe,
  output logic [NUM_INPUTS-1:0] alarm
);
  for (genvar g = 0; g < NUM_INPUTS; g++) begin : gSlot
    logic [LIM_W-1:0] countdown;
    logic             alarmQ;
    logic             hit;
    logic             swClr;
    logic             autoDone;

    assign hit      = strobes.raise && (strobes.raiseIdx == IDX_W'(g + 1));
    assign swClr    = !autoClear && clearStrobe[g];
    assign autoDone = autoClear && strobes.tick && alarmQ && (countdown <= LIM_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        alarmQ    <= 1'b0;
        countdown <= '0;
      end else if (hit) begin
        alarmQ    <= 1'b1;           // a raise beats any clear in the same cycle
        countdown <= strobes.limit;
      end else if (swClr || autoDone) begin
        alarmQ    <= 1'b0;
        countdown <= '0;
      end else if (autoClear && strobes.tick && alarmQ) begin
        countdown <= countdown - LIM_W'(1);
      end
    end

    assign alarm[g] = alarmQ;
  end
endmodule

// File: rtl/lockTimeoutAlarm.sv
module lockTimeoutAlarm
  import lockTimeoutPkg::*;
#(
  parameter int unsigned NUM_INPUTS = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic                  pathIsPrimary,
  input  logic                  primaryLocked,
  input  logic [IDX_W-1:0]      selIndex,
  input  logic [TOV_W-1:0]      timeoutVal,
  input  logic [MULT_W-1:0]     multCode,
  input  logic                  autoClear,
  input  logic [NUM_INPUTS-1:0] clearStrobe,
  output logic [NUM_INPUTS-1:0] alarm,
  output logic [NUM_INPUTS-1:0] qualMask
);
  ctrlStrobes_t strobes;

  lockTimeoutCtrl #(.NUM_INPUTS(NUM_INPUTS)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .secTick      (secTick),
    .pathIsPrimary(pathIsPrimary),
    .primaryLocked(primaryLocked),
    .selIndex     (selIndex),
    .timeoutVal   (timeoutVal),
    .multCode     (multCode),
    .strobes      (strobes)
  );

  lockTimeoutDatapath #(.NUM_INPUTS(NUM_INPUTS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .autoClear  (autoClear),
    .clearStrobe(clearStrobe),
    .alarm      (alarm)
  );

  assign qualMask = ~alarm;
endmodule

// File: rtl/lockTimeoutChecker.sv
module lockTimeoutChecker
  import lockTimeoutPkg::*;
#(
  parameter int unsigned NUM_INPUTS = 14
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  secTick,
  input logic                  pathIsPrimary,
  input logic [TOV_W-1:0]      timeoutVal,
  input logic                  autoClear,
  input logic [NUM_INPUTS-1:0] clearStrobe,
  input logic [NUM_INPUTS-1:0] alarm
);
  p_raise_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|(alarm & ~$past(alarm))) |-> $past(secTick));

  p_single_raise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(alarm & ~$past(alarm)) <= 1);

  p_zero_timeout_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timeoutVal) == '0) |-> ((alarm & ~$past(alarm)) == '0));

  p_aux_path_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pathIsPrimary) |-> ((alarm & ~$past(alarm)) == '0));

  p_sw_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(autoClear) |-> (($past(alarm) & ~alarm & ~$past(clearStrobe)) == '0));

  p_auto_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(autoClear) && !$past(secTick)) |-> (($past(alarm) & ~alarm) == '0));
endmodule

bind lockTimeoutAlarm lockTimeoutChecker #(.NUM_INPUTS(NUM_INPUTS)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .secTick      (secTick),
  .pathIsPrimary(pathIsPrimary),
  .timeoutVal   (timeoutVal),
  .autoClear    (autoClear),
  .clearStrobe  (clearStrobe),
  .alarm        (alarm)
);

// File: tb/lockTimeoutAlarm_tb.sv
module lockTimeoutAlarm_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        pathIsPrimary = 1'b1;
  logic        primaryLocked = 1'b0;
  logic [3:0]  selIndex = '0;
  logic [5:0]  timeoutVal = '0;
  logic [1:0]  multCode = '0;
  logic        autoClear = 1'b0;
  logic [13:0] clearStrobe = '0;
  logic [13:0] alarm;
  logic [13:0] qualMask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lockTimeoutAlarm dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .pathIsPrimary(pathIsPrimary),
    .primaryLocked(primaryLocked), .selIndex(selIndex), .timeoutVal(timeoutVal),
    .multCode(multCode), .autoClear(autoClear), .clearStrobe(clearStrobe),
    .alarm(alarm), .qualMask(qualMask)
  );

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [5:0] tov, input logic [1:0] mc, input logic ac,
                       input logic [3:0] idx);
    @(negedge clk);
    rstN = 1'b0; secTick = 1'b0; clearStrobe = '0; primaryLocked = 1'b0;
    pathIsPrimary = 1'b1; timeoutVal = tov; multCode = mc; autoClear = ac; selIndex = idx;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tickN(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) secTick = 1'b1;
      @(negedge clk) secTick = 1'b0;
    end
  endtask

  task automatic setIndex(input logic [3:0] idx);
    @(negedge clk) selIndex = idx;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseClear(input logic [13:0] m);
    @(negedge clk) clearStrobe = m;
    @(negedge clk) clearStrobe = '0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 alarm in reset", alarm, 14'h0);
    check("R11 mask in reset", qualMask, 14'h3fff);
  endtask

  task automatic testBasic();
    setup(6'd3, 2'b00, 1'b0, 4'd5);
    tickN(2);
    check("R1 before limit", alarm, 14'h0);
    tickN(1);
    check("R1 R2 raise on input 5", alarm, 14'h0010);
    check("R10 mask excludes input 5", qualMask, 14'h3fef);
    tickN(2);
    check("R6 alarm sticky", alarm, 14'h0010);
    @(negedge clk) primaryLocked = 1'b1;
    pulseClear(14'h0008);
    check("R6 other bit clear no effect", alarm, 14'h0010);
    pulseClear(14'h0010);
    check("R6 software clear", alarm, 14'h0);
    check("R10 mask restored", qualMask, 14'h3fff);
  endtask

  task automatic testMultiplier();
    setup(6'd2, 2'b10, 1'b0, 4'd7);
    tickN(7);
    check("R1 x4 before limit", alarm, 14'h0);
    tickN(1);
    check("R1 x4 at limit 8", alarm, 14'h0040);
    setup(6'd3, 2'b01, 1'b0, 4'd14);
    tickN(5);
    check("R1 x2 before limit", alarm, 14'h0);
    tickN(1);
    check("R1 x2 at limit 6 input 14", alarm, 14'h2000);
    setup(6'd1, 2'b11, 1'b0, 4'd1);
    tickN(7);
    check("R1 x8 before limit", alarm, 14'h0);
    tickN(1);
    check("R1 x8 at limit 8", alarm, 14'h0001);
  endtask

  task automatic testRestart();
    setup(6'd4, 2'b00, 1'b0, 4'd3);
    tickN(3);
    setIndex(4'd9);
    tickN(3);
    check("R3 index change restarts", alarm, 14'h0);
    tickN(1);
    check("R3 new index raised only", alarm, 14'h0100);
    setup(6'd4, 2'b00, 1'b0, 4'd3);
    tickN(3);
    @(negedge clk) primaryLocked = 1'b1;
    tickN(1);
    @(negedge clk) primaryLocked = 1'b0;
    tickN(3);
    check("R3 lock restarts", alarm, 14'h0);
    tickN(1);
    check("R3 raise after relock loss", alarm, 14'h0004);
  endtask

  task automatic testDisabled();
    setup(6'd0, 2'b11, 1'b0, 4'd2);
    tickN(20);
    check("R4 zero timeout", alarm, 14'h0);
    setup(6'd2, 2'b00, 1'b0, 4'd2);
    @(negedge clk) pathIsPrimary = 1'b0;
    tickN(10);
    check("R5 auxiliary path", alarm, 14'h0);
    @(negedge clk) pathIsPrimary = 1'b1;
    setIndex(4'd0);
    tickN(10);
    check("R2 index 0", alarm, 14'h0);
    setIndex(4'd15);
    tickN(10);
    check("R2 index 15", alarm, 14'h0);
  endtask

  task automatic testAutoClear();
    setup(6'd3, 2'b00, 1'b1, 4'd2);
    tickN(3);
    check("R7 raise in auto mode", alarm, 14'h0002);
    @(negedge clk) primaryLocked = 1'b1;
    pulseClear(14'h0002);
    check("R7 clear strobe ignored", alarm, 14'h0002);
    tickN(2);
    check("R7 before expiry", alarm, 14'h0002);
    tickN(1);
    check("R7 expired", alarm, 14'h0);
  endtask

  task automatic testIndependent();
    setup(6'd4, 2'b00, 1'b1, 4'd1);
    tickN(4);
    check("R8 first alarm", alarm, 14'h0001);
    setIndex(4'd2);
    tickN(2);
    check("R8 first still counting", alarm, 14'h0001);
    tickN(2);
    check("R8 first expires second raised", alarm, 14'h0002);
    @(negedge clk) primaryLocked = 1'b1;
    tickN(3);
    check("R8 second own countdown", alarm, 14'h0002);
    tickN(1);
    check("R8 second expired", alarm, 14'h0);
  endtask

  task automatic testSetWins();
    setup(6'd2, 2'b00, 1'b0, 4'd4);
    tickN(1);
    @(negedge clk) begin secTick = 1'b1; clearStrobe = 14'h0008; end
    @(negedge clk) begin secTick = 1'b0; clearStrobe = '0; end
    check("R9 set beats clear", alarm, 14'h0008);
    @(negedge clk) primaryLocked = 1'b1;
    pulseClear(14'h0008);
    check("R9 later clear works", alarm, 14'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testBasic();
    testMultiplier();
    testRestart();
    testDisabled();
    testAutoClear();
    testIndependent();
    testSetWins();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule